// File: doc/BRIEF.md
# GPIO Interrupt Trigger Controller

This block watches the low, interrupt-capable pins of a 32-pin GPIO bank and folds every armed condition into one interrupt request line. The pin levels arrive already synchronized to the block clock. A small register bus writes the per-pin trigger configuration, acknowledges pending events and reads the pending status back.

Each interrupt-capable pin owns four configuration bits packed into one control word: a rise enable, a fall enable, a debounce enable and a level-mode select. Software never writes the word as a whole. One address ORs the written ones into it and another address clears the written ones from it, so two agents can change different pins without a read-modify-write. In edge mode a detected transition is latched as pending until software writes a one to its acknowledge bit. In level mode the rise and fall enables become polarity selects, and the pending bit tracks the live pin condition.

Top module: `gpio_irq_trigger`

## Requirements
- R1: After reset the control word reads 0, the status reads 0 and `irq_o` is low.
- R2: A write to 0x18 sets the written one bits of the control word, and a write to 0x1C clears them. A read at 0x18 returns the word. For pin i the rise enable is bit i, the fall enable is bit 8+i, the debounce enable is bit 16+i and the level select is bit 24+i.
- R3: In edge mode the block detects a 0-to-1 change of pin i when its rise enable is set, a 1-to-0 change when its fall enable is set, and either change when both are set. With debounce off, status bit i reads 1 after the first clock edge that samples the new level.
- R4: An edge-mode status bit stays set until a write to 0x20 carries a one in that bit position. Bits written as zero at 0x20 keep their value. A read at 0x24 returns the status.
- R5: When an edge event and an acknowledge of the same pin fall in the same cycle, the status bit is left set.
- R6: In level mode a set rise enable makes status bit i equal to the pin being high, and a set fall enable makes it equal to the pin being low. The bit follows the condition, so an acknowledge while the condition holds leaves it at 1.
- R7: A pin whose rise and fall enables are both clear produces no new pending bit. A bit that was already pending keeps its value until it is acknowledged.
- R8: Only pins 0 to 7 can raise interrupts. Activity on pins 8 to 31 never shows, and status bits 31:8 always read 0.
- R9: With debounce enabled, a new level counts only after it has been sampled on 4 consecutive clock edges. A pulse of 3 cycles or less is ignored.
- R10: `irq_o` is the OR of status bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl_i | input | 32 | Synchronized pin levels |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 6 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a pin edge that lands in exactly the cycle when software acknowledges the same pin. A close second is a debounced pulse that ends one cycle before it would have been accepted. Directed sequences line up the pin change and the acknowledge write in the same bus cycle, and they drive pulses of exactly three and exactly four cycles. A long random phase then mixes set, clear and acknowledge writes with random pin activity and random debounce and level-mode choices. Every cycle of that phase is compared against a bench model built from the requirements.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Decoded register access kind
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL_SET,
        ACC_CTRL_CLR,
        ACC_PEND_CLR,
        ACC_STATUS
    } acc_e;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IRQ_PINS = 8,
    parameter int ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] OFS_SET  = 6'h18,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 6'h1C,
    parameter logic [ADDR_W-1:0] OFS_PCLR = 6'h20,
    parameter logic [ADDR_W-1:0] OFS_STAT = 6'h24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [4*IRQ_PINS-1:0] ctrl_o,
    output logic [IRQ_PINS-1:0] pend_clr_o,
    output acc_e                sel_o
);
    localparam int CW = 4 * IRQ_PINS;

    typedef struct packed {
        logic [CW-1:0] ctrl;
    } regs_t;

    regs_t st_d, st_q;
    acc_e  sel;

    always_comb begin
        if (addr_i == OFS_SET)       sel = ACC_CTRL_SET;
        else if (addr_i == OFS_CLR)  sel = ACC_CTRL_CLR;
        else if (addr_i == OFS_PCLR) sel = ACC_PEND_CLR;
        else if (addr_i == OFS_STAT) sel = ACC_STATUS;
        else                         sel = ACC_NONE;

        st_d = st_q;
        if (wr_i && sel == ACC_CTRL_SET) begin
            st_d.ctrl = st_q.ctrl | wdata_i[CW-1:0];
        end else if (wr_i && sel == ACC_CTRL_CLR) begin
            st_d.ctrl = st_q.ctrl & ~wdata_i[CW-1:0];
        end

        pend_clr_o = (wr_i && sel == ACC_PEND_CLR) ? wdata_i[IRQ_PINS-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign sel_o  = sel;
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
    parameter int DB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic db_en_i,
    output logic lvl_q_o,
    output logic lvl_d_o
);
    localparam int CNT_W = $clog2(DB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } db_t;

    db_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!db_en_i) begin
            st_d.lvl = pin_i;
            st_d.cnt = '0;
        end else if (pin_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.lvl = pin_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_q_o = st_q.lvl;
    assign lvl_d_o = st_d.lvl;
endmodule

// File: rtl/gpio_irq_pending.sv
module gpio_irq_pending #(
    parameter int IRQ_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IRQ_PINS-1:0] lvl_q_i,
    input  logic [IRQ_PINS-1:0] lvl_d_i,
    input  logic [IRQ_PINS-1:0] rise_en_i,
    input  logic [IRQ_PINS-1:0] fall_en_i,
    input  logic [IRQ_PINS-1:0] lvl_mode_i,
    input  logic [IRQ_PINS-1:0] pend_clr_i,
    output logic [IRQ_PINS-1:0] pend_o
);
    typedef struct packed {
        logic [IRQ_PINS-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;
    logic [IRQ_PINS-1:0] went_up, went_down, cond, event_hit;

    always_comb begin
        went_up   = lvl_d_i & ~lvl_q_i;
        went_down = ~lvl_d_i & lvl_q_i;
        event_hit = (rise_en_i & went_up) | (fall_en_i & went_down);
        cond      = (rise_en_i & lvl_d_i) | (fall_en_i & ~lvl_d_i);
        st_d      = st_q;
        for (int i = 0; i < IRQ_PINS; i++) begin
            if (lvl_mode_i[i]) begin
                st_d.pend[i] = cond[i];
            end else begin
                st_d.pend[i] = (st_q.pend[i] & ~pend_clr_i[i]) | event_hit[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger
    import gpio_irq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_PINS  = 32,
    parameter int IRQ_PINS  = 8,
    parameter int ADDR_W    = 6,
    parameter int DB_CYCLES = 4,
    parameter logic [ADDR_W-1:0] OFS_SET  = 6'h18,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 6'h1C,
    parameter logic [ADDR_W-1:0] OFS_PCLR = 6'h20,
    parameter logic [ADDR_W-1:0] OFS_STAT = 6'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int CW = 4 * IRQ_PINS;

    logic [CW-1:0]       ctrl_word;
    logic [IRQ_PINS-1:0] pend_status;
    logic [IRQ_PINS-1:0] pend_clr;
    logic [IRQ_PINS-1:0] lvl_q, lvl_d;
    logic [IRQ_PINS-1:0] rise_en, fall_en, db_en, lvl_mode;
    acc_e                sel;
    logic                unused_pins;

    assign unused_pins = ^pin_lvl_i[NUM_PINS-1:IRQ_PINS];

    gpio_irq_regs #(
        .DATA_W(DATA_W), .IRQ_PINS(IRQ_PINS), .ADDR_W(ADDR_W),
        .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR),
        .OFS_PCLR(OFS_PCLR), .OFS_STAT(OFS_STAT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .ctrl_o     (ctrl_word),
        .pend_clr_o (pend_clr),
        .sel_o      (sel)
    );

    assign rise_en  = ctrl_word[IRQ_PINS-1:0];
    assign fall_en  = ctrl_word[2*IRQ_PINS-1:IRQ_PINS];
    assign db_en    = ctrl_word[3*IRQ_PINS-1:2*IRQ_PINS];
    assign lvl_mode = ctrl_word[4*IRQ_PINS-1:3*IRQ_PINS];

    for (genvar g = 0; g < IRQ_PINS; g++) begin : g_pin
        gpio_irq_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_lvl_i[g]),
            .db_en_i (db_en[g]),
            .lvl_q_o (lvl_q[g]),
            .lvl_d_o (lvl_d[g])
        );
    end

    gpio_irq_pending #(.IRQ_PINS(IRQ_PINS)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_q_i    (lvl_q),
        .lvl_d_i    (lvl_d),
        .rise_en_i  (rise_en),
        .fall_en_i  (fall_en),
        .lvl_mode_i (lvl_mode),
        .pend_clr_i (pend_clr),
        .pend_o     (pend_status)
    );

    always_comb begin
        case (sel)
            ACC_CTRL_SET: bus_rdata_o = DATA_W'(ctrl_word);
            ACC_STATUS:   bus_rdata_o = DATA_W'(pend_status);
            default:      bus_rdata_o = '0;
        endcase
    end

    assign irq_o = |pend_status;
endmodule

// File: rtl/gpio_irq_trigger_chk.sv
module gpio_irq_trigger_chk #(
    parameter int DATA_W   = 32,
    parameter int IRQ_PINS = 8,
    parameter int ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] OFS_SET  = 6'h18,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 6'h1C,
    parameter logic [ADDR_W-1:0] OFS_PCLR = 6'h20,
    parameter logic [ADDR_W-1:0] OFS_STAT = 6'h24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr_i,
    input logic [ADDR_W-1:0]     bus_addr_i,
    input logic [DATA_W-1:0]     bus_wdata_i,
    input logic [DATA_W-1:0]     bus_rdata_o,
    input logic                  irq_o,
    input logic [4*IRQ_PINS-1:0] ctrl,
    input logic [IRQ_PINS-1:0]   pend
);
    localparam int CW = 4 * IRQ_PINS;

    logic [IRQ_PINS-1:0] ack_mask, lvl_sel, rise_sel, fall_sel, hold_edge, quiet;

    always_comb begin
        ack_mask  = (bus_wr_i && bus_addr_i == OFS_PCLR) ? bus_wdata_i[IRQ_PINS-1:0] : '0;
        rise_sel  = ctrl[IRQ_PINS-1:0];
        fall_sel  = ctrl[2*IRQ_PINS-1:IRQ_PINS];
        lvl_sel   = ctrl[4*IRQ_PINS-1:3*IRQ_PINS];
        hold_edge = pend & ~lvl_sel & ~ack_mask;
        quiet     = ~pend & ~lvl_sel & ~rise_sel & ~fall_sel;
    end

    assert_ctrl_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_SET) |=>
            ((ctrl & $past(bus_wdata_i[CW-1:0])) == $past(bus_wdata_i[CW-1:0])));

    assert_ctrl_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_CLR) |=>
            ((ctrl & $past(bus_wdata_i[CW-1:0])) == '0));

    assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hold_edge) & ~pend) == '0));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(quiet) & pend) == '0));

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFS_STAT) |-> (bus_rdata_o[DATA_W-1:IRQ_PINS] == '0));

    assert_irq_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFS_STAT) |-> (irq_o == (bus_rdata_o != '0)));
endmodule

bind gpio_irq_trigger gpio_irq_trigger_chk #(
    .DATA_W(DATA_W), .IRQ_PINS(IRQ_PINS), .ADDR_W(ADDR_W),
    .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR),
    .OFS_PCLR(OFS_PCLR), .OFS_STAT(OFS_STAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .ctrl        (ctrl_word),
    .pend        (pend_status)
);

// File: tb/gpio_irq_trigger_bench.sv
`timescale 1ns/1ps
module gpio_irq_trigger_bench;
    localparam logic [5:0] A_SET = 6'h18, A_CLR = 6'h1C, A_PCLR = 6'h20, A_STAT = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [31:0] m_ctrl = '0;
    logic [7:0]  m_stat = '0;
    logic [7:0]  m_filt = '0;
    int          m_cnt [8];

    always #2 clk = ~clk;

    gpio_irq_trigger u_gpio_irq_trigger (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(pin), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: model next state from the requirements, then commit.
    task automatic step();
        logic [31:0] nctrl;
        logic [7:0]  nstat, nfilt;
        int          ncnt [8];
        nctrl = m_ctrl;
        nstat = m_stat;
        nfilt = m_filt;
        for (int i = 0; i < 8; i++) begin
            logic rs, fl, db, lv, ack, ev;
            rs = m_ctrl[i]; fl = m_ctrl[8+i]; db = m_ctrl[16+i]; lv = m_ctrl[24+i];
            ncnt[i] = m_cnt[i];
            if (!db) begin
                nfilt[i] = pin[i]; ncnt[i] = 0;
            end else if (pin[i] == m_filt[i]) begin
                ncnt[i] = 0;
            end else if (m_cnt[i] == 3) begin
                nfilt[i] = pin[i]; ncnt[i] = 0;
            end else begin
                ncnt[i] = m_cnt[i] + 1;
            end
            ack = bus_wr && bus_addr == A_PCLR && bus_wdata[i];
            ev  = (rs && nfilt[i] && !m_filt[i]) || (fl && !nfilt[i] && m_filt[i]);
            if (lv) nstat[i] = (rs && nfilt[i]) || (fl && !nfilt[i]);
            else    nstat[i] = (m_stat[i] && !ack) || ev;
        end
        if (bus_wr && bus_addr == A_SET) nctrl = m_ctrl | bus_wdata;
        if (bus_wr && bus_addr == A_CLR) nctrl = m_ctrl & ~bus_wdata;
        @(posedge clk);
        if (rst_n) begin
            m_ctrl = nctrl; m_stat = nstat; m_filt = nfilt;
            for (int i = 0; i < 8; i++) m_cnt[i] = ncnt[i];
        end
        @(negedge clk);
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic chk_stat(input string tag, input logic [7:0] exp);
        logic [31:0] v;
        rd(A_STAT, v);
        chk(tag, v, {24'b0, exp});
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, |exp});
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rd(A_SET, v);  chk("R1 ctrl after reset", v, 32'h0);
        chk_stat("R1 status after reset", 8'h00);
        rst_n = 1'b1;
        step();

        // R2 set / clear / readback
        bwrite(A_SET, 32'h8000_0001);
        rd(A_SET, v); chk("R2 set readback", v, 32'h8000_0001);
        bwrite(A_CLR, 32'h8000_0000);
        rd(A_SET, v); chk("R2 clear readback", v, 32'h0000_0001);

        // R3 rising on pin 0, R10 irq
        pin[0] = 1'b1; step();
        chk_stat("R3 rise pin0 R10", 8'h01);
        step(); step();
        chk_stat("R4 pending held", 8'h01);
        bwrite(A_PCLR, 32'h0000_0002);
        chk_stat("R4 ack other bit keeps", 8'h01);
        bwrite(A_PCLR, 32'h0000_0001);
        chk_stat("R4 ack clears", 8'h00);

        // R3 falling on pin 1
        bwrite(A_SET, 32'h0000_0200);
        pin[1] = 1'b1; step();
        chk_stat("R3 fall-only ignores rise", 8'h00);
        pin[1] = 1'b0; step();
        chk_stat("R3 fall pin1", 8'h02);
        bwrite(A_PCLR, 32'h2);

        // R3 both edges on pin 2
        bwrite(A_SET, 32'h0000_0404);
        pin[2] = 1'b1; step();
        chk_stat("R3 both rise pin2", 8'h04);
        bwrite(A_PCLR, 32'h4);
        pin[2] = 1'b0; step();
        chk_stat("R3 both fall pin2", 8'h04);
        bwrite(A_PCLR, 32'h4);
        chk_stat("R4 cleared pin2", 8'h00);

        // R5 edge together with ack
        pin[0] = 1'b0; step();
        chk_stat("R5 no event on fall", 8'h00);
        pin[0] = 1'b1;
        bwrite(A_PCLR, 32'h1);
        chk_stat("R5 edge wins over ack", 8'h01);
        bwrite(A_PCLR, 32'h1);
        rd(A_SET, v); chk("R2 accumulated word", v, 32'h0000_0605);
        bwrite(A_CLR, 32'hFFFF_FFFF);
        rd(A_SET, v); chk("R2 clear all", v, 32'h0);

        // R6 level high then level low on pin 3
        bwrite(A_SET, 32'h0800_0008);
        chk_stat("R6 level high idle", 8'h00);
        pin[3] = 1'b1; step();
        chk_stat("R6 level high active", 8'h08);
        bwrite(A_PCLR, 32'h8);
        chk_stat("R6 ack while held", 8'h08);
        pin[3] = 1'b0; step();
        chk_stat("R6 level drops", 8'h00);
        bwrite(A_CLR, 32'h0000_0008);
        bwrite(A_SET, 32'h0000_0800);
        step();
        chk_stat("R6 level low active", 8'h08);
        pin[3] = 1'b1; step();
        chk_stat("R6 level low released", 8'h00);
        bwrite(A_CLR, 32'h0800_0800);

        // R7 masking
        bwrite(A_SET, 32'h0000_0010);
        pin[4] = 1'b1; step();
        chk_stat("R7 armed pin4", 8'h10);
        bwrite(A_CLR, 32'h0000_0010);
        pin[4] = 1'b0; step(); pin[4] = 1'b1; step();
        chk_stat("R7 old pending kept", 8'h10);
        bwrite(A_PCLR, 32'h10);
        pin[4] = 1'b0; step(); pin[4] = 1'b1; step();
        chk_stat("R7 masked quiet", 8'h00);

        // R8 upper pins
        pin = '0; step();
        bwrite(A_PCLR, 32'hFF);
        bwrite(A_SET, 32'h0000_FFFF);
        pin = 32'hFFFF_FF00; step();
        chk_stat("R8 upper pins rise", 8'h00);
        pin = 32'h0; step();
        chk_stat("R8 upper pins fall", 8'h00);
        bwrite(A_CLR, 32'hFFFF_FFFF);

        // R9 debounce on pin 5
        bwrite(A_SET, 32'h0020_0020);
        pin[5] = 1'b1; step(); step(); step();
        pin[5] = 1'b0; step(); step();
        chk_stat("R9 3-cycle pulse ignored", 8'h00);
        pin[5] = 1'b1; step(); step(); step();
        chk_stat("R9 not yet after 3", 8'h00);
        step();
        chk_stat("R9 accepted after 4", 8'h20);
        bwrite(A_CLR, 32'hFFFF_FFFF);
        bwrite(A_PCLR, 32'hFF);
        chk_stat("R4 cleared before random", 8'h00);

        // random phase against the model (R3 R4 R5 R6 R7 R9 R10)
        for (int n = 0; n < 4000; n++) begin
            int op;
            if (($urandom % 3) == 0) pin[7:0] = pin[7:0] ^ 8'($urandom);
            pin[31:8] = 24'($urandom);
            op = $urandom % 8;
            if (op == 0)      bwrite(A_SET, $urandom & 32'hFFFF_FFFF);
            else if (op == 1) bwrite(A_CLR, $urandom);
            else if (op == 2) bwrite(A_PCLR, $urandom);
            else              step();
            chk_stat("R4 random status", m_stat);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %h expected %h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule